// File: doc/BRIEF.md
# Two-Button Tug-of-War Game Controller

This block runs a tug-of-war game on a row of LEDs with exactly one light lit. Two players each own a push button. Every press pulls the light one place toward the presser's end. When a player pulls the light past their own end, that player wins the round and their score goes up by one. The row then goes dark for one cycle, and the light comes back to the centre for the next round.

A mode switch replaces player two with an automatic opponent. At a fixed tick rate, this opponent compares a speed switch value against a free-running linear feedback shift register. It "presses" whenever the switch value is the larger of the two, so a higher setting gives a faster but still irregular opponent.

Each side's score is a small saturating counter, meant to drive that side's seven-segment display through an external decoder.

Top module: `tug_game_top`

## Requirements
- R1: After reset exactly one LED is lit, at index 4 of the nine (`led == 9'b000010000`), and both scores read 0.
- R2: Player one's button moves the light one index up (toward `led[8]`), and player two's button moves it one index down (toward `led[0]`). Each press moves it exactly once, however long the button is held.
- R3: If both move requests land in the same cycle, the light does not move.
- R4: A move up from index 8 is a win for player one, and a move down from index 0 is a win for player two. In the cycle after the winning move, all LEDs are dark and the winner's score has risen by one. One cycle later the light is back at index 4.
- R5: A score stops at 7. A further win by that player leaves it at 7, and the round still restarts from the centre.
- R6: With `solo_mode` high, player two's button has no effect on the light.
- R7: The automatic opponent acts only while `solo_mode` is high, and only on a tick. It acts when `speed_sw` is strictly greater than the current 10-bit shift-register value, so `speed_sw == 0` never moves the light.
- R8: With `speed_sw` at its maximum in solo mode, the opponent wins rounds on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_p1 | input | 1 | Raw button of player one (pulls up) |
| btn_p2 | input | 1 | Raw button of player two (pulls down) |
| solo_mode | input | 1 | 1 selects the automatic opponent in place of player two |
| speed_sw | input | 10 | Opponent speed setting |
| led | output | 9 | LED row, one-hot or all dark |
| score_p1 | output | 3 | Rounds won by player one |
| score_p2 | output | 3 | Rounds won by player two or the opponent |

## Verification
Two move requests can arrive in the same cycle: one from each player's edge detector, or one from player one and one from the opponent. The bench raises both raw buttons on the same falling clock edge. The synchronisers then deliver the two pulses together, and the bench checks that the light stays where it was. A winning move and the following re-centre are judged cycle-exactly. The bench counts the three register stages from button to LED and samples a dark row, then the centre light, on successive cycles.

// File: rtl/tug_pkg.sv
package tug_pkg;
  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;

  function automatic move_e resolve_move(input logic up_req, input logic down_req);
    if (up_req && !down_req) return MV_UP;
    if (down_req && !up_req) return MV_DOWN;
    return MV_NONE;
  endfunction
endpackage

// File: rtl/press_pulse.sv
module press_pulse #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= raw;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], raw};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign pulse = sync_q[STAGES-1] & ~prev_q;

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/auto_opponent.sv
module auto_opponent #(
  parameter int          LFSR_W   = 10,
  parameter logic [LFSR_W-1:0] TAP_MASK = 10'h240,
  parameter int          TICK_DIV = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [LFSR_W-1:0] speed,
  output logic              fire
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0]     tick_cnt;
  logic [LFSR_W-1:0] lfsr_q;
  logic              tick_now;
  logic              beats;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
    return {v[LFSR_W-2:0], ^(v & TAP_MASK)};
  endfunction

  assign tick_now = (tick_cnt == CW'(TICK_DIV - 1));
  assign beats    = (speed > lfsr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      lfsr_q   <= LFSR_W'(1);
      fire     <= 1'b0;
    end else begin
      tick_cnt <= tick_now ? '0 : tick_cnt + 1'b1;
      lfsr_q   <= lfsr_step(lfsr_q);
      fire     <= enable & tick_now & beats;
    end
  end

  p_fire_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    fire |-> ($past(tick_now) && $past(enable)));
  p_zero_never_r7: assert property (@(posedge clk) disable iff (rst)
    fire |-> ($past(speed) != '0));
  p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
endmodule

// File: rtl/rope_position.sv
module rope_position
  import tug_pkg::*;
#(
  parameter int N_LEDS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              down_req,
  output logic [N_LEDS-1:0] led,
  output logic              win_up,
  output logic              win_down
);
  localparam int PW     = $clog2(N_LEDS);
  localparam int CENTRE = (N_LEDS - 1) / 2;
  localparam int TOP    = N_LEDS - 1;

  logic [PW-1:0] pos_q;
  logic          dark_q;
  move_e         mv;

  always_comb begin
    mv = dark_q ? MV_NONE : resolve_move(up_req, down_req);
    win_up   = (mv == MV_UP)   && (pos_q == PW'(TOP));
    win_down = (mv == MV_DOWN) && (pos_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= PW'(CENTRE);
      dark_q <= 1'b0;
    end else if (dark_q) begin
      pos_q  <= PW'(CENTRE);
      dark_q <= 1'b0;
    end else if (win_up || win_down) begin
      dark_q <= 1'b1;
    end else if (mv == MV_UP) begin
      pos_q <= pos_q + 1'b1;
    end else if (mv == MV_DOWN) begin
      pos_q <= pos_q - 1'b1;
    end
  end

  always_comb begin
    led = '0;
    if (!dark_q) led[pos_q] = 1'b1;
  end

  p_led_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(led));
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (!dark_q && !win_up && !win_down) |=>
      (pos_q == $past(pos_q) || pos_q == $past(pos_q) + 1'b1 || pos_q == $past(pos_q) - 1'b1));
  p_tie_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (up_req && down_req && !dark_q) |=> ($stable(pos_q) && !dark_q));
  p_win_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (win_up || win_down) |=> dark_q);
  p_recentre_r4: assert property (@(posedge clk) disable iff (rst)
    dark_q |=> (!dark_q && pos_q == PW'(CENTRE)));
endmodule

// File: rtl/score_keeper.sv
module score_keeper #(
  parameter int W   = 3,
  parameter int MAX = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         win,
  output logic [W-1:0] score
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == W'(MAX)) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      score <= '0;
    else if (win) score <= sat_inc(score);
  end

  p_win_counts_r4: assert property (@(posedge clk) disable iff (rst)
    win |=> (score == $past(score) + 1'b1 || $past(score) == W'(MAX)));
  p_saturate_r5: assert property (@(posedge clk) disable iff (rst)
    (score == W'(MAX)) |=> (score == W'(MAX)));
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
    !win |=> $stable(score));
endmodule

// File: rtl/tug_game_top.sv
module tug_game_top #(
  parameter int N_LEDS    = 9,
  parameter int SCORE_W   = 3,
  parameter int SCORE_MAX = 7,
  parameter int LFSR_W    = 10,
  parameter int TICK_DIV  = 1024,
  parameter int SYNC_LEN  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               btn_p1,
  input  logic               btn_p2,
  input  logic               solo_mode,
  input  logic [LFSR_W-1:0]  speed_sw,
  output logic [N_LEDS-1:0]  led,
  output logic [SCORE_W-1:0] score_p1,
  output logic [SCORE_W-1:0] score_p2
);
  logic p1_pulse, p2_pulse, bot_fire;
  logic up_req, down_req, win_up, win_down;

  press_pulse #(.STAGES(SYNC_LEN)) u_p1 (
    .clk(clk), .rst(rst), .raw(btn_p1), .pulse(p1_pulse));
  press_pulse #(.STAGES(SYNC_LEN)) u_p2 (
    .clk(clk), .rst(rst), .raw(btn_p2), .pulse(p2_pulse));

  auto_opponent #(.LFSR_W(LFSR_W), .TICK_DIV(TICK_DIV)) u_bot (
    .clk(clk), .rst(rst), .enable(solo_mode), .speed(speed_sw), .fire(bot_fire));

  assign up_req   = p1_pulse;
  assign down_req = solo_mode ? bot_fire : p2_pulse;

  rope_position #(.N_LEDS(N_LEDS)) u_rope (
    .clk(clk), .rst(rst), .up_req(up_req), .down_req(down_req),
    .led(led), .win_up(win_up), .win_down(win_down));

  score_keeper #(.W(SCORE_W), .MAX(SCORE_MAX)) u_s1 (
    .clk(clk), .rst(rst), .win(win_up), .score(score_p1));
  score_keeper #(.W(SCORE_W), .MAX(SCORE_MAX)) u_s2 (
    .clk(clk), .rst(rst), .win(win_down), .score(score_p2));

  p_solo_masks_p2_r6: assert property (@(posedge clk) disable iff (rst)
    (solo_mode && !bot_fire) |-> !down_req);
  p_single_winner_r4: assert property (@(posedge clk) disable iff (rst)
    !(win_up && win_down));
endmodule

// File: tb/sim_tug_game_top.sv
module sim_tug_game_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_p1 = 1'b0, btn_p2 = 1'b0, solo_mode = 1'b0;
  logic [9:0] speed_sw = '0;
  logic [8:0] led;
  logic [2:0] score_p1, score_p2;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tug_game_top #(.TICK_DIV(8)) u0 (
    .clk(clk), .rst(rst), .btn_p1(btn_p1), .btn_p2(btn_p2),
    .solo_mode(solo_mode), .speed_sw(speed_sw),
    .led(led), .score_p1(score_p1), .score_p2(score_p2));

  function automatic logic [8:0] at(input int idx);
    return 9'(1) << idx;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic press(input bit p1, input bit p2, input int hold);
    btn_p1 = p1; btn_p2 = p2;
    repeat (hold) @(negedge clk);
    btn_p1 = 0; btn_p2 = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int pos;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(led == at(4), "R1 led", led, at(4));
    check(score_p1 == 0, "R1 score_p1", score_p1, 0);
    check(score_p2 == 0, "R1 score_p2", score_p2, 0);

    // R2 long hold moves once
    press(1, 0, 30);
    check(led == at(5), "R2 up hold", led, at(5));
    press(0, 1, 6);
    check(led == at(4), "R2 down", led, at(4));
    press(0, 1, 6);
    check(led == at(3), "R2 down again", led, at(3));
    press(1, 0, 2);
    check(led == at(4), "R2 short press", led, at(4));

    // R3 simultaneous presses
    press(1, 1, 6);
    check(led == at(4), "R3 tie", led, at(4));

    // R4 player one win, cycle exact
    pos = 4;
    for (int k = 0; k < 4; k++) begin press(1, 0, 6); pos++; end
    check(led == at(pos), "R4 at top", led, at(pos));
    btn_p1 = 1;
    repeat (3) @(posedge clk);
    #1;
    check(led == 9'd0, "R4 dark", led, 0);
    check(score_p1 == 1, "R4 score_p1", score_p1, 1);
    @(posedge clk); #1;
    check(led == at(4), "R4 recentre", led, at(4));
    btn_p1 = 0;
    repeat (6) @(negedge clk);

    // R4 player two win
    for (int k = 0; k < 5; k++) press(0, 1, 6);
    check(score_p2 == 1, "R4 score_p2", score_p2, 1);
    check(led == at(4), "R4 p2 recentre", led, at(4));

    // R5 saturation: six more rounds reach 7, a further one stays at 7
    for (int r = 0; r < 6; r++)
      for (int k = 0; k < 5; k++) press(1, 0, 6);
    check(score_p1 == 7, "R5 reach max", score_p1, 7);
    for (int k = 0; k < 5; k++) press(1, 0, 6);
    check(score_p1 == 7, "R5 saturated", score_p1, 7);
    check(led == at(4), "R5 round restarts", led, at(4));
    check(score_p2 == 1, "R5 other side", score_p2, 1);

    // R6 solo: player two button ignored; R7 speed zero never acts
    solo_mode = 1; speed_sw = 0;
    press(0, 1, 6);
    check(led == at(4), "R6 p2 ignored", led, at(4));
    repeat (400) @(negedge clk);
    check(led == at(4), "R7 speed zero", led, at(4));
    press(1, 0, 6);
    check(led == at(5), "R6 p1 still works", led, at(5));

    // R8 fast opponent wins by itself
    speed_sw = 10'h3FF;
    for (int c = 0; c < 4000 && score_p2 < 3; c++) @(negedge clk);
    check(score_p2 >= 3, "R8 opponent wins", score_p2, 3);

    // R7 opponent silent in two-player mode
    solo_mode = 0;
    repeat (4) @(negedge clk);
    pos = led;
    repeat (400) @(negedge clk);
    check(led == 9'(pos), "R7 disabled in duo", led, pos);

    done = 1;
    finish_run();
  end
endmodule